// File: doc/BRIEF.md
# Square-Wave Melody Tone Generator

The block plays a tune as a square wave on one dedicated, non-inverted tone output. Each note is a 16-bit word. A sequencer fetches the words one at a time over a request/valid read port, starting from a programmable start address. Each word gives three things: a pitch divider, a length in duration units, and an end marker.

All timing runs on a base-tick strobe, nominally 32.768 kHz. A 6-bit divider N gives a tone of base/N, which covers roughly 529 Hz to 2979 Hz for N from 62 down to 11. A 4-bit tempo value, taken at the start of each note, scales the duration unit. When the note that carries the end marker has finished, the block raises a one-cycle melody-end interrupt and stops fetching. A separate buzzer drive output gives the base tick divided by eight (4 kHz at 32.768 kHz) while the block is enabled.

Software starts a tune by raising `enable` and stops it at once by clearing it. Stopping abandons the tune silently and raises no interrupt.

Top module: `melody_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `tone_out`, `buzz_out`, `fetch_req` and `end_irq` are all 0.
- R2: A 0-to-1 change of `enable` starts a tune at `start_addr`. `fetch_req` stays high with `fetch_addr` stable until `fetch_valid` is seen. Each later note is fetched from the previous address plus one.
- R3: The word fields are as follows. Bits [5:0] are the divider N. Bits [11:6] are the length L. Bit 15 is the end marker. Bits [14:12] have no effect on the tone or on the timing.
- R4: For N >= 2, `tone_out` goes high when a note starts. It stays high for floor(N/2) base ticks, then stays low for N - floor(N/2) ticks, and repeats with a period of N ticks.
- R5: A divider of 0 or 1 is a rest: `tone_out` stays low for the whole duration of the note.
- R6: A note lasts L x T x UNIT_TICKS base ticks, counted from the clock after its word is accepted. A length of 0 counts as 1.
- R7: The tempo value T is taken from `tempo` when a note starts, and later changes do not affect that note. A tempo of 0 counts as 1, so 15 distinct settings exist.
- R8: `tone_out` is low whenever no note is playing: while a word is being fetched, after the tune has ended, and while the block is disabled.
- R9: After the note that carries the end marker has run out, `end_irq` is high for exactly one clock. No further fetch follows until the tune is restarted.
- R10: When `enable` is sampled low, the next clock forces `tone_out` and `fetch_req` low and `end_irq` does not fire. Raising `enable` again restarts the tune from `start_addr`.
- R11: While `enable` is high, `buzz_out` toggles every 4 base ticks, for a period of 8 ticks. While `enable` is low, `buzz_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One-cycle strobe at the base tone rate |
| enable | input | 1 | A rising edge starts the tune; low stops it |
| start_addr | input | ADDR_W | Address of the first note word |
| tempo | input | 4 | Duration scale, taken when each note starts |
| fetch_req | output | 1 | Note word requested |
| fetch_addr | output | ADDR_W | Address of the requested word |
| fetch_valid | input | 1 | Requested word present on fetch_data |
| fetch_data | input | 16 | Note word |
| tone_out | output | 1 | Square-wave tone |
| buzz_out | output | 1 | Buzzer drive, base tick divided by 8 |
| end_irq | output | 1 | One-cycle melody-end pulse |

## Verification
The hardest case to bring about is a note whose duration is an exact multiple of its period. There, the tick that ends the note coincides with a rising edge of the tone, and the tone must not rise on that tick. The stimulus sets up this case and several near misses by picking divider, length and tempo combinations. It also uses odd dividers and read latencies of several cycles. A scoreboard then compares, for every note, the tick count, the high-tick count and the number of rising edges. The stop case is reached by waiting until the tone is high in the middle of a note and then dropping `enable`.

// File: rtl/melody_pkg.sv
// melody_pkg: shared widths, the note word layout and the sequencer state type.
// Assumes 16-bit note words whose field positions are fixed by the requirements.
package melody_pkg;
    localparam int WORD_W    = 16;
    localparam int PITCH_W   = 6;
    localparam int LEN_W     = 6;
    localparam int TEMPO_W   = 4;
    localparam int PITCH_LSB = 0;
    localparam int LEN_LSB   = 6;
    localparam int LAST_BIT  = 15;
    localparam int MIN_DIV   = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_PLAY  = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic               last;
        logic [LEN_W-1:0]   len;
        logic [PITCH_W-1:0] div;
    } note_t;

    // Split a fetched word into its fields; bits [14:12] are dropped.
    function automatic note_t unpack_note(input logic [WORD_W-1:0] w);
        note_t n;
        n.last = w[LAST_BIT];
        n.len  = w[LEN_LSB +: LEN_W];
        n.div  = w[PITCH_LSB +: PITCH_W];
        return n;
    endfunction
endpackage

// File: rtl/melody_pitch.sv
// melody_pitch: square-wave phase counter for one note.
// On load the divider is captured and the tone starts high unless the note is a rest.
// Assumes load and halt never occur in the same cycle.
module melody_pitch
    import melody_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               run,
    input  logic               halt,
    input  logic               tick,
    input  logic [PITCH_W-1:0] div_in,
    output logic               tone
);
    logic [PITCH_W-1:0] div_q;
    logic [PITCH_W-1:0] phase_q;
    logic [PITCH_W-1:0] half_w;
    logic [PITCH_W-1:0] phase_len;
    logic               audible;

    assign audible   = (div_q >= PITCH_W'(MIN_DIV));
    assign half_w    = div_q >> 1;
    assign phase_len = tone ? half_w : (div_q - half_w);

    // Phase counting and tone toggling on each base tick of a playing note.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= '0;
            tone    <= 1'b0;
        end else if (load) begin
            div_q   <= div_in;
            phase_q <= '0;
            tone    <= (div_in >= PITCH_W'(MIN_DIV));
        end else if (halt || !run) begin
            phase_q <= '0;
            tone    <= 1'b0;
        end else if (tick && audible) begin
            if (phase_q + PITCH_W'(1) == phase_len) begin
                phase_q <= '0;
                tone    <= !tone;
            end else begin
                phase_q <= phase_q + PITCH_W'(1);
            end
        end
    end

    // R4
    phase_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && audible) |-> (phase_q < phase_len));

    // R5
    rest_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !audible) |-> !tone);
endmodule

// File: rtl/melody_dur.sv
// melody_dur: counts the base ticks of one note; length x tempo x UNIT_TICKS.
// A length or tempo of zero counts as one. done is a combinational strobe on the final tick.
module melody_dur
    import melody_pkg::*;
#(
    parameter int UNIT_TICKS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               run,
    input  logic               tick,
    input  logic [LEN_W-1:0]   len_in,
    input  logic [TEMPO_W-1:0] tempo_in,
    output logic               done
);
    localparam int UNIT_W = $clog2(UNIT_TICKS + 1);
    localparam int CNT_W  = LEN_W + TEMPO_W + UNIT_W;

    logic [CNT_W-1:0]   left_q;
    logic [CNT_W-1:0]   span;
    logic [LEN_W-1:0]   len_eff;
    logic [TEMPO_W-1:0] tmp_eff;

    assign len_eff = (len_in == '0) ? LEN_W'(1) : len_in;
    assign tmp_eff = (tempo_in == '0) ? TEMPO_W'(1) : tempo_in;
    assign span    = CNT_W'(len_eff) * CNT_W'(tmp_eff) * CNT_W'(UNIT_TICKS);
    assign done    = run && tick && (left_q == CNT_W'(1));

    // Remaining-tick counter; loaded at note start, decremented per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= span;
        end else if (run && tick) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    // R6
    dur_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (left_q != '0));
endmodule

// File: rtl/melody_buzz.sv
// melody_buzz: buzzer drive, toggling every HALF_TICKS base ticks while enabled.
// Held low and restarted whenever enable is low.
module melody_buzz #(
    parameter int HALF_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic buzz
);
    localparam int BW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

    logic [BW-1:0] cnt_q;

    // Tick divider producing the buzzer square wave.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
            buzz  <= 1'b0;
        end else if (tick) begin
            if (cnt_q == BW'(HALF_TICKS - 1)) begin
                cnt_q <= '0;
                buzz  <= !buzz;
            end else begin
                cnt_q <= cnt_q + BW'(1);
            end
        end
    end

    // R11
    buzz_edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(buzz) |-> ($past(tick) || !$past(enable)));
endmodule

// File: rtl/melody_seq.sv
// melody_seq: note word sequencer. A rising enable starts fetching at start_addr;
// each word is played until its duration runs out. The end-marked note ends the tune
// with a one-cycle irq. Low enable returns the sequencer to idle at once.
// Assumes the memory holds fetch_valid for one cycle per request.
module melody_seq
    import melody_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              rvalid,
    input  logic              last_in,
    input  logic              note_done,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              load,
    output logic              playing,
    output logic              irq
);
    seq_state_t state_q;
    logic       en_q;
    logic       last_q;

    assign req     = (state_q == SEQ_FETCH);
    assign load    = req && rvalid && enable;
    assign playing = (state_q == SEQ_PLAY);

    // Enable history for start-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Sequencer state, address and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            addr    <= '0;
            last_q  <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!enable) begin
                state_q <= SEQ_IDLE;
            end else begin
                case (state_q)
                    SEQ_IDLE: begin
                        if (!en_q) begin
                            state_q <= SEQ_FETCH;
                            addr    <= start_addr;
                        end
                    end
                    SEQ_FETCH: begin
                        if (rvalid) begin
                            state_q <= SEQ_PLAY;
                            last_q  <= last_in;
                        end
                    end
                    SEQ_PLAY: begin
                        if (note_done) begin
                            if (last_q) begin
                                state_q <= SEQ_DONE;
                                irq     <= 1'b1;
                            end else begin
                                state_q <= SEQ_FETCH;
                                addr    <= addr + ADDR_W'(1);
                            end
                        end
                    end
                    default: state_q <= SEQ_DONE;
                endcase
            end
        end
    end

    // R2
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rvalid && enable) |=> (req && $stable(addr)));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    irq_after_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(playing));

    // R10
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!req && !irq && !playing));
endmodule

// File: rtl/melody_gen.sv
// melody_gen: square-wave melody tone generator top. It joins the word sequencer,
// the duration counter, the pitch phase counter and the buzzer divider.
// Assumes base_tick is a single-cycle strobe and the memory answers each request once.
module melody_gen
    import melody_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int UNIT_TICKS = 4,
    parameter int BUZZ_HALF  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_tick,
    input  logic               enable,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [TEMPO_W-1:0] tempo,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    input  logic               fetch_valid,
    input  logic [WORD_W-1:0]  fetch_data,
    output logic               tone_out,
    output logic               buzz_out,
    output logic               end_irq
);
    note_t word_f;
    logic  load_w;
    logic  playing_w;
    logic  done_w;
    logic  halt_w;

    assign word_f = unpack_note(fetch_data);
    assign halt_w = done_w || !enable;

    melody_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start_addr (start_addr),
        .rvalid     (fetch_valid),
        .last_in    (word_f.last),
        .note_done  (done_w),
        .req        (fetch_req),
        .addr       (fetch_addr),
        .load       (load_w),
        .playing    (playing_w),
        .irq        (end_irq)
    );

    melody_dur #(.UNIT_TICKS(UNIT_TICKS)) u_dur (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .run      (playing_w),
        .tick     (base_tick),
        .len_in   (word_f.len),
        .tempo_in (tempo),
        .done     (done_w)
    );

    melody_pitch u_pitch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_w),
        .run    (playing_w),
        .halt   (halt_w),
        .tick   (base_tick),
        .div_in (word_f.div),
        .tone   (tone_out)
    );

    melody_buzz #(.HALF_TICKS(BUZZ_HALF)) u_buzz (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .tick   (base_tick),
        .buzz   (buzz_out)
    );

    // R8
    silent_outside_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !playing_w |-> !tone_out);
endmodule

// File: tb/melody_gen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected record per note; the monitor
// measures each note at the ports and compares.
module melody_gen_tb;
    localparam int ADDR_W   = 8;
    localparam int UNIT     = 4;
    localparam int TICK_DIV = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              base_tick = 1'b0;
    logic              enable = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [3:0]        tempo = '0;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_valid = 1'b0;
    logic [15:0]       fetch_data = '0;
    logic              tone_out, buzz_out, end_irq;

    melody_gen #(.ADDR_W(ADDR_W), .UNIT_TICKS(UNIT), .BUZZ_HALF(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .enable(enable),
        .start_addr(start_addr), .tempo(tempo), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .tone_out(tone_out), .buzz_out(buzz_out), .end_irq(end_irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int addr;
        int ticks;
        int highs;
        int rises;
        bit last;
    } note_exp_t;

    note_exp_t   sb[$];
    logic [15:0] mem [0:255];
    int checks = 0;
    int errors = 0;
    int mem_lat = 0;
    int lat_cnt = 0;
    int tdiv = 0;
    bit tick_on = 1'b0;
    bit mon_on = 1'b0;
    bit in_note = 1'b0;
    bit prev_tone = 1'b0;
    bit prev_buzz = 1'b0;
    bit bz_valid = 1'b0;
    int bz_ticks = 0;
    int m_ticks = 0, m_highs = 0, m_rises = 0, m_addr = 0;
    int irq_seen = 0;
    int gap_err = 0;

    task automatic check(input string rq, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [15:0] mk(input bit last, input int len, input int dv, input int junk);
        return {last, 3'(junk), 6'(len), 6'(dv)};
    endfunction

    // Base tick strobe, one cycle in TICK_DIV.
    always @(posedge clk) begin
        #1;
        if (tick_on) begin
            if (tdiv == TICK_DIV - 1) begin tdiv = 0; base_tick = 1'b1; end
            else begin tdiv++; base_tick = 1'b0; end
        end else base_tick = 1'b0;
    end

    // Note memory with a programmable read latency.
    always @(posedge clk) begin
        #1;
        if (fetch_valid) fetch_valid = 1'b0;
        else if (fetch_req) begin
            if (lat_cnt >= mem_lat) begin
                fetch_valid = 1'b1;
                fetch_data  = mem[fetch_addr];
                lat_cnt     = 0;
            end else lat_cnt++;
        end else lat_cnt = 0;
    end

    task automatic close_note(input bit irq_now);
        note_exp_t e;
        if (sb.size() == 0) begin
            check("R9", 1, 0, "note played beyond end marker");
            return;
        end
        e = sb.pop_front();
        check("R2", m_addr, e.addr, "note address");
        check("R6 R7", m_ticks, e.ticks, "note duration ticks");
        check(e.rises == 0 ? "R5" : "R3 R4", m_highs, e.highs, "high ticks");
        check(e.rises == 0 ? "R5" : "R4", m_rises, e.rises, "rising edges");
        check("R9", int'(irq_now), int'(e.last), "end pulse at note close");
    endtask

    // Monitor: per-note measurement, gap silence, buzzer period, irq count.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (in_note && (fetch_req || end_irq)) begin
                close_note(end_irq);
                in_note = 1'b0;
            end
            if (in_note) begin
                if (base_tick) begin
                    m_ticks++;
                    if (tone_out) m_highs++;
                end
                if (tone_out && !prev_tone) m_rises++;
            end else if (tone_out) gap_err++;
            if (fetch_valid && fetch_req && enable) begin
                in_note = 1'b1;
                m_ticks = 0; m_highs = 0; m_rises = 0;
                m_addr  = int'(fetch_addr);
            end
        end
        if (rst_n && end_irq) irq_seen++;
        if (!rst_n || !enable) begin
            bz_valid = 1'b0;
            bz_ticks = 0;
        end else begin
            if (buzz_out != prev_buzz) begin
                if (bz_valid) check("R11", bz_ticks, 4, "base ticks per buzzer half period");
                bz_valid = 1'b1;
                bz_ticks = 0;
            end
            if (base_tick) bz_ticks++;
        end
        prev_buzz = buzz_out;
        prev_tone = tone_out;
    end

    // Driver: push expected records for the tune starting at first.
    task automatic push_melody(input int first, input int tmp);
        int a, p, l, t, d, h;
        bit fin;
        logic [15:0] w;
        note_exp_t e;
        a = first;
        fin = 1'b0;
        while (!fin) begin
            w = mem[a];
            p = int'(w[5:0]);
            l = (w[11:6] == 0) ? 1 : int'(w[11:6]);
            t = (tmp == 0) ? 1 : tmp;
            d = l * t * UNIT;
            e.addr  = a;
            e.ticks = d;
            e.last  = w[15];
            if (p < 2) begin
                e.highs = 0;
                e.rises = 0;
            end else begin
                h = p / 2;
                e.highs = (d / p) * h + (((d % p) < h) ? (d % p) : h);
                e.rises = (d + p - 1) / p;
            end
            sb.push_back(e);
            fin = w[15];
            a++;
        end
    endtask

    task automatic run_melody(input int first, input int tmp, input int lat, input int new_tmp);
        int irq0;
        push_melody(first, tmp);
        @(posedge clk); #1;
        mem_lat = lat; tempo = 4'(tmp); start_addr = ADDR_W'(first); enable = 1'b1;
        irq0 = irq_seen;
        if (new_tmp >= 0) begin
            repeat (20) @(posedge clk);
            #1 tempo = 4'(new_tmp);
        end
        wait (irq_seen != irq0);
        repeat (60) @(posedge clk);
        @(negedge clk);
        check("R9", irq_seen - irq0, 1, "end pulses per tune");
        check("R9", sb.size(), 0, "notes left unplayed");
        check("R9", int'(fetch_req), 0, "fetch after end");
        check("R8", int'(tone_out), 0, "tone after end");
        @(posedge clk); #1 enable = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        int irq0;
        for (int i = 0; i < 256; i++) mem[i] = mk(1'b1, 1, 0, 0);
        mem[0]  = mk(1'b0, 3, 20, 0);
        mem[1]  = mk(1'b0, 2, 0, 0);
        mem[2]  = mk(1'b0, 1, 11, 0);
        mem[3]  = mk(1'b0, 2, 62, 7);
        mem[4]  = mk(1'b0, 1, 1, 0);
        mem[5]  = mk(1'b1, 0, 37, 0);
        mem[16] = mk(1'b0, 5, 2, 0);
        mem[17] = mk(1'b0, 4, 13, 0);
        mem[18] = mk(1'b1, 63, 25, 0);
        mem[32] = mk(1'b1, 2, 50, 0);
        tick_on = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1", int'(tone_out) + int'(buzz_out) + int'(fetch_req) + int'(end_irq), 0, "outputs in reset");
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(tone_out) + int'(buzz_out) + int'(fetch_req) + int'(end_irq), 0, "outputs after reset");
        mon_on = 1'b1;
        run_melody(0, 3, 0, -1);
        run_melody(16, 0, 3, -1);
        run_melody(32, 15, 1, 7);

        // Stop in the middle of a high tone phase (R10).
        mon_on = 1'b0;
        in_note = 1'b0;
        @(posedge clk); #1;
        mem_lat = 0; tempo = 4'd3; start_addr = '0; enable = 1'b1;
        irq0 = irq_seen;
        repeat (40) @(posedge clk);
        wait (tone_out == 1'b1);
        @(posedge clk); #1 enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10", int'(tone_out), 0, "tone one clock after stop");
        check("R10", int'(fetch_req), 0, "fetch one clock after stop");
        check("R11", int'(buzz_out), 0, "buzzer while disabled");
        repeat (300) @(negedge clk);
        check("R10", irq_seen - irq0, 0, "end pulse after stop");
        check("R10", int'(tone_out) + int'(fetch_req), 0, "outputs stay quiet after stop");

        // Restart from the start address (R10).
        sb.delete();
        in_note = 1'b0;
        mon_on = 1'b1;
        run_melody(0, 3, 2, -1);
        check("R8", gap_err, 0, "tone cycles outside notes");
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_up();
    end
endmodule